// File: doc/BRIEF.md
# Command Ring Pointer Manager

This block tracks the consumer side of a ring of 32-bit command words held in a region of shared memory. The producer publishes four byte offsets at the head of that region: the lower bound of the ring, its upper bound, the producer's next write position and the consumer's read position. When the surrounding logic signals that the ring has been configured, the block checks these offsets for word alignment and sensible size. If they pass, it captures the bounds and the read position. A ring that fails the checks is left unconfigured and always reads as empty.

Once the ring is configured and enabled, the block reports whether it holds unread words by comparing the producer's live write offset with its own read offset. Each fetch request that arrives while the ring is not empty issues one read on a synchronous word-read memory port. The read position then moves forward one word, and it reloads the lower bound when it reaches or passes the upper bound. The memory returns the word one cycle later and the block presents it together with a valid strobe. The updated read offset is strobed out so it can be written back into the shared header, which lets the producer see how far the consumer has got.

Top module: `ring_cmd_ptr`

## Requirements
- R1: After reset, `cfg_ok_o` is 0, `empty_o` is 1, `fetch_valid_o` is 0, `stop_wr_o` is 0 and `stop_o` is 0.
- R2: `empty_o` is 1 whenever `cfg_ok_o` is 0 or `enable_i` is 0. Otherwise it is 1 exactly when `hdr_next_i` equals `stop_o`.
- R3: A `cfg_req_i` cycle with `enable_i` high and offsets that pass R4 and R5 sets `cfg_ok_o` at the next edge, loads `stop_o` from `hdr_stop_i`, and captures `hdr_min_i` and `hdr_max_i` as the ring bounds.
- R4: A `cfg_req_i` cycle is rejected, and `cfg_ok_o` becomes 0, if any of `hdr_min_i`, `hdr_max_i`, `hdr_next_i` or `hdr_stop_i` has bit 0 or bit 1 set.
- R5: A `cfg_req_i` cycle is also rejected if max is above 65536, if max is below min + 10240, or if min is below 16 (the four-word header). max = 65536, max = min + 10240 and min = 16 are each accepted.
- R6: A cycle with `enable_i` low clears `cfg_ok_o` at the next edge. It stays cleared after `enable_i` returns high until a new accepted `cfg_req_i`.
- R7: A cycle with `fetch_req_i` high and `empty_o` low drives `mem_rd_o` high with `mem_addr_o` = `stop_o` >> 2 in that same cycle. In the following cycle `fetch_valid_o` is 1 and `fetch_data_o` carries the memory word.
- R8: Each such fetch sets `stop_o` to `stop_o` + 4 at the edge, or to the captured min if that sum is at or above the captured max. `stop_wr_o` is 1 for the one cycle after that edge.
- R9: A fetch request while `empty_o` is 1 is ignored: `mem_rd_o` stays 0, no valid strobe follows, and `stop_o` is unchanged.
- R10: Fetches may be issued on consecutive cycles, one word per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Ring enable; low forces empty and drops configuration |
| cfg_req_i | input | 1 | One-cycle strobe: validate and adopt the header offsets |
| hdr_min_i | input | 32 | Ring lower bound, byte offset |
| hdr_max_i | input | 32 | Ring upper bound, byte offset |
| hdr_next_i | input | 32 | Producer write offset (live) |
| hdr_stop_i | input | 32 | Initial consumer read offset |
| cfg_ok_o | output | 1 | Ring configured and accepted |
| empty_o | output | 1 | No unread words available |
| fetch_req_i | input | 1 | Request one command word |
| fetch_valid_o | output | 1 | Fetched word is on `fetch_data_o` |
| fetch_data_o | output | 32 | Fetched command word |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 14 | Memory word address |
| mem_rdata_i | input | 32 | Memory read data, one cycle after the strobe |
| stop_o | output | 32 | Current consumer read offset |
| stop_wr_o | output | 1 | Strobe to write `stop_o` back into the header |

## Verification
`empty_o`, `mem_rd_o` and `mem_addr_o` follow from the current inputs and state in the same cycle, so the bench checks them 1 ns after it drives inputs on the falling edge. `cfg_ok_o`, `stop_o`, `stop_wr_o` and the fetched word with its valid strobe are due one rising edge after their cause, so the bench samples them on the next falling edge. A reference model in the bench is advanced at that edge and gives the expected values. Directed cases cover each bound at and just past its limit, a wrap from the top of the ring, and the enable drop; seeded random configurations and fetch traffic then exercise everything else.

// File: rtl/ring_ptr_pkg.sv
// Shared constants and types for the command ring pointer manager.
// Assumes byte offsets are 32 bits wide and ring words are 32 bits.
package ring_ptr_pkg;
    localparam int WORD_W = 32;
    localparam int WORD_BYTES = WORD_W / 8;

    // Ring bounds captured at configuration time.
    typedef struct packed {
        logic [31:0] base;
        logic [31:0] limit;
    } ring_bounds_t;
endpackage

// File: rtl/ring_cfg_check.sv
// Combinational validation of the four header offsets.
// Assumes offsets are byte offsets into a region of RING_BYTES bytes
// whose first HDR_BYTES bytes hold the header itself.
module ring_cfg_check #(
    parameter int PTR_W      = 32,
    parameter int RING_BYTES = 65536,
    parameter int MIN_SPAN   = 10240,
    parameter int HDR_BYTES  = 16
) (
    input  logic [PTR_W-1:0] lo_i,
    input  logic [PTR_W-1:0] hi_i,
    input  logic [PTR_W-1:0] nxt_i,
    input  logic [PTR_W-1:0] stp_i,
    output logic             ok_o
);
    localparam logic [PTR_W:0] LIM_X  = (PTR_W+1)'(RING_BYTES);
    localparam logic [PTR_W:0] SPAN_X = (PTR_W+1)'(MIN_SPAN);
    localparam logic [PTR_W:0] HDR_X  = (PTR_W+1)'(HDR_BYTES);

    logic aligned, fits, spans, clears_hdr;

    // Evaluate every acceptance rule in parallel.
    always_comb begin
        aligned    = ((lo_i | hi_i | nxt_i | stp_i) & PTR_W'(3)) == '0;
        fits       = {1'b0, hi_i} <= LIM_X;
        spans      = {1'b0, hi_i} >= ({1'b0, lo_i} + SPAN_X);
        clears_hdr = {1'b0, lo_i} >= HDR_X;
        ok_o       = aligned && fits && spans && clears_hdr;
    end
endmodule

// File: rtl/ring_stop_ptr.sv
// Consumer read-offset register: loads on configuration, advances one
// word per fetch and reloads the ring base at or beyond the limit.
// Assumes load and advance are never requested in the same cycle.
module ring_stop_ptr #(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [PTR_W-1:0] load_val_i,
    input  logic             adv_i,
    input  logic [PTR_W-1:0] base_i,
    input  logic [PTR_W-1:0] limit_i,
    output logic [PTR_W-1:0] stop_o,
    output logic             stop_wr_o
);
    logic [PTR_W:0] step;

    // Next sequential offset, one bit wider so a carry is not lost.
    always_comb step = {1'b0, stop_o} + (PTR_W+1)'(ring_ptr_pkg::WORD_BYTES);

    // Read offset register and its write-back strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_o    <= '0;
            stop_wr_o <= 1'b0;
        end else begin
            stop_wr_o <= adv_i;
            if (load_i)
                stop_o <= load_val_i;
            else if (adv_i)
                stop_o <= (step >= {1'b0, limit_i}) ? base_i : step[PTR_W-1:0];
        end
    end
endmodule

// File: rtl/ring_fetch_port.sv
// Return path of the word-read port: tracks the one-cycle read latency
// and presents the memory word with a valid strobe.
// Assumes memory data is valid exactly one cycle after the read strobe.
module ring_fetch_port #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    // Delay the issue strobe by the memory latency.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= issue_i;
    end

    // Memory data passes straight through.
    always_comb data_o = rdata_i;
endmodule

// File: rtl/ring_cmd_ptr.sv
// Top of the command ring pointer manager: validates the header offsets
// on a configuration strobe, reports empty, and fetches ring words.
// Assumes hdr_next_i tracks the producer's header word continuously.
module ring_cmd_ptr #(
    parameter int PTR_W      = 32,
    parameter int RING_BYTES = 65536,
    parameter int MIN_SPAN   = 10240,
    parameter int HDR_BYTES  = 16,
    parameter int ADDR_W     = $clog2(RING_BYTES) - 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           enable_i,
    input  logic                           cfg_req_i,
    input  logic [PTR_W-1:0]               hdr_min_i,
    input  logic [PTR_W-1:0]               hdr_max_i,
    input  logic [PTR_W-1:0]               hdr_next_i,
    input  logic [PTR_W-1:0]               hdr_stop_i,
    output logic                           cfg_ok_o,
    output logic                           empty_o,
    input  logic                           fetch_req_i,
    output logic                           fetch_valid_o,
    output logic [ring_ptr_pkg::WORD_W-1:0] fetch_data_o,
    output logic                           mem_rd_o,
    output logic [ADDR_W-1:0]              mem_addr_o,
    input  logic [ring_ptr_pkg::WORD_W-1:0] mem_rdata_i,
    output logic [PTR_W-1:0]               stop_o,
    output logic                           stop_wr_o
);
    localparam int SHIFT = $clog2(ring_ptr_pkg::WORD_BYTES);

    ring_ptr_pkg::ring_bounds_t bounds_q;
    logic hdr_ok, accept, cfg_ok_q, issue;

    ring_cfg_check #(
        .PTR_W(PTR_W), .RING_BYTES(RING_BYTES),
        .MIN_SPAN(MIN_SPAN), .HDR_BYTES(HDR_BYTES)
    ) u_check (
        .lo_i(hdr_min_i), .hi_i(hdr_max_i),
        .nxt_i(hdr_next_i), .stp_i(hdr_stop_i), .ok_o(hdr_ok)
    );

    // A configuration strobe is adopted only when enabled and valid.
    always_comb accept = cfg_req_i && enable_i && hdr_ok;

    // Configured flag: dropped by disable or by a rejected strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         cfg_ok_q <= 1'b0;
        else if (!enable_i) cfg_ok_q <= 1'b0;
        else if (cfg_req_i) cfg_ok_q <= hdr_ok;
    end

    // Capture the ring bounds on an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bounds_q <= '0;
        else if (accept) bounds_q <= '{base: hdr_min_i, limit: hdr_max_i};
    end

    // Empty status and fetch issue decision.
    always_comb begin
        empty_o    = !cfg_ok_q || !enable_i || (hdr_next_i == stop_o);
        issue      = fetch_req_i && !empty_o;
        mem_rd_o   = issue;
        mem_addr_o = stop_o[SHIFT +: ADDR_W];
        cfg_ok_o   = cfg_ok_q;
    end

    ring_stop_ptr #(.PTR_W(PTR_W)) u_stop (
        .clk(clk), .rst_n(rst_n),
        .load_i(accept), .load_val_i(hdr_stop_i),
        .adv_i(issue), .base_i(bounds_q.base), .limit_i(bounds_q.limit),
        .stop_o(stop_o), .stop_wr_o(stop_wr_o)
    );

    ring_fetch_port #(.DATA_W(ring_ptr_pkg::WORD_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .issue_i(issue),
        .rdata_i(mem_rdata_i), .valid_o(fetch_valid_o), .data_o(fetch_data_o)
    );
endmodule

// File: rtl/ring_cmd_ptr_chk.sv
// Temporal checks for ring_cmd_ptr, attached with bind below.
module ring_cmd_ptr_chk #(
    parameter int PTR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable_i,
    input logic             cfg_req_i,
    input logic             cfg_ok_o,
    input logic             empty_o,
    input logic             mem_rd_o,
    input logic             fetch_valid_o,
    input logic [PTR_W-1:0] stop_o,
    input logic             stop_wr_o,
    input logic [PTR_W-1:0] base_now
);
    assert_no_read_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> !mem_rd_o);
    assert_valid_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> fetch_valid_o);
    assert_valid_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_o |-> $past(mem_rd_o));
    assert_stop_step_or_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> (stop_o == $past(stop_o) + PTR_W'(4)) || (stop_o == base_now));
    assert_stop_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_o && !cfg_req_i) |=> $stable(stop_o));
    assert_writeback_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr_o |-> $past(mem_rd_o));
    assert_disable_drops_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !cfg_ok_o);
    assert_cfg_rise_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_ok_o) |-> $past(cfg_req_i));
    assert_stop_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ok_o |-> (stop_o[1:0] == 2'b00));
endmodule

bind ring_cmd_ptr ring_cmd_ptr_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .cfg_req_i(cfg_req_i),
    .cfg_ok_o(cfg_ok_o), .empty_o(empty_o), .mem_rd_o(mem_rd_o),
    .fetch_valid_o(fetch_valid_o), .stop_o(stop_o), .stop_wr_o(stop_wr_o),
    .base_now(bounds_q.base)
);

// File: tb/tb_ring_cmd_ptr.sv
module tb_ring_cmd_ptr;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0, cfg_req_i = 1'b0, fetch_req_i = 1'b0;
    logic [31:0] hdr_min_i = '0, hdr_max_i = '0, hdr_next_i = '0, hdr_stop_i = '0;
    logic        cfg_ok_o, empty_o, fetch_valid_o, mem_rd_o, stop_wr_o;
    logic [31:0] fetch_data_o, mem_rdata_i, stop_o;
    logic [13:0] mem_addr_o;

    int checks = 0, fails = 0;
    bit done = 0;

    // Reference model state.
    bit          m_ok = 0;
    logic [31:0] m_stop = '0, m_min = '0, m_max = '0;

    always #(CLK_NS/2) clk = ~clk;

    ring_cmd_ptr dut (.*);

    function automatic logic [31:0] memf(input logic [13:0] a);
        return {a, ~a, 4'h9} ^ 32'h5A3C_96E1;
    endfunction

    // Memory model: one-cycle read latency.
    always @(posedge clk) mem_rdata_i <= memf(mem_addr_o);

    function automatic bit hdr_valid(input logic [31:0] mn, mx, nx, st);
        longint lmn = longint'(mn), lmx = longint'(mx);
        return (((mn | mx | nx | st) & 32'd3) == 0) && (lmx <= 65536)
            && (lmx >= lmn + 10240) && (lmn >= 16);
    endfunction

    task automatic chk(input bit cond, input string req, input logic [31:0] act, exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // One clock cycle, entered and left at a falling edge.
    task automatic cycle(input bit req);
        bit exp_empty, exp_rd;
        logic [31:0] nxt;
        logic [13:0] addr;
        fetch_req_i = req;
        #1;
        exp_empty = !m_ok || !enable_i || (hdr_next_i == m_stop);
        exp_rd = req && !exp_empty;
        chk(empty_o == exp_empty, "R2 empty", 32'(empty_o), 32'(exp_empty));
        chk(mem_rd_o == exp_rd, exp_rd ? "R7 read strobe" : "R9 no read", 32'(mem_rd_o), 32'(exp_rd));
        addr = m_stop[15:2];
        if (exp_rd) chk(mem_addr_o == addr, "R7 address", 32'(mem_addr_o), 32'(addr));
        @(posedge clk);
        if (!enable_i) m_ok = 0;
        if (exp_rd) begin
            nxt = m_stop + 4;
            m_stop = (nxt >= m_max) ? m_min : nxt;
        end
        @(negedge clk);
        chk(fetch_valid_o == exp_rd, "R7 valid", 32'(fetch_valid_o), 32'(exp_rd));
        if (exp_rd) chk(fetch_data_o == memf(addr), "R10 data", fetch_data_o, memf(addr));
        chk(stop_wr_o == exp_rd, "R8 writeback strobe", 32'(stop_wr_o), 32'(exp_rd));
        chk(stop_o == m_stop, exp_rd ? "R8 stop advance" : "R9 stop held", stop_o, m_stop);
        chk(cfg_ok_o == m_ok, "R6 cfg state", 32'(cfg_ok_o), 32'(m_ok));
        fetch_req_i = 1'b0;
    endtask

    task automatic configure(input logic [31:0] mn, mx, nx, st, input string req);
        bit v;
        hdr_min_i = mn; hdr_max_i = mx; hdr_next_i = nx; hdr_stop_i = st;
        cfg_req_i = 1'b1;
        v = hdr_valid(mn, mx, nx, st);
        @(posedge clk);
        if (!enable_i) m_ok = 0;
        else begin
            m_ok = v;
            if (v) begin m_stop = st; m_min = mn; m_max = mx; end
        end
        @(negedge clk);
        cfg_req_i = 1'b0;
        chk(cfg_ok_o == m_ok, req, 32'(cfg_ok_o), 32'(m_ok));
        chk(stop_o == m_stop, "R3 stop load", stop_o, m_stop);
    endtask

    initial begin
        #(CLK_NS * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cfg_ok_o == 0, "R1 cfg_ok", 32'(cfg_ok_o), 0);
        chk(empty_o == 1, "R1 empty", 32'(empty_o), 1);
        chk(fetch_valid_o == 0, "R1 valid", 32'(fetch_valid_o), 0);
        chk(stop_wr_o == 0, "R1 wr", 32'(stop_wr_o), 0);
        chk(stop_o == 0, "R1 stop", stop_o, 0);
        rst_n = 1'b1;
        enable_i = 1'b1;
        @(negedge clk);

        // R5 boundaries accepted: min 16, max = min + 10240
        configure(16, 10256, 16, 16, "R5 min/span boundary accept");
        cycle(1);                       // R9: empty, ignored
        hdr_next_i = 32;
        repeat (5) cycle(1);            // R7 R8 R10: stops at next
        // R8 wrap from the top word
        configure(16, 10256, 20, 10252, "R3 accept");
        cycle(1); cycle(1);
        // R10 back-to-back through wrap
        configure(16, 10256, 24, 10244, "R3 accept");
        repeat (5) cycle(1);

        // R4 each field misaligned
        configure(18, 10260, 32, 32, "R4 min misaligned");
        configure(16, 10258, 32, 32, "R4 max misaligned");
        configure(16, 10256, 33, 32, "R4 next misaligned");
        configure(16, 10256, 32, 34, "R4 stop misaligned");
        cycle(1);
        // R5 size limits
        configure(16, 65536, 16, 100, "R5 max at limit accept");
        configure(16, 65540, 16, 100, "R5 max above limit");
        configure(100, 10336, 100, 100, "R5 span short by one word");
        configure(12, 20000, 12, 12, "R5 min inside header");
        configure(0, 20000, 0, 0, "R5 min zero");

        // R6 enable drop
        configure(64, 20000, 128, 64, "R3 accept");
        cycle(1);
        enable_i = 1'b0;
        cycle(1);
        enable_i = 1'b1;
        cycle(1); cycle(1);             // still unconfigured
        configure(64, 20000, 128, 64, "R6 reconfigure");
        // R6: cfg strobe while disabled is ignored
        enable_i = 1'b0;
        configure(64, 20000, 128, 64, "R6 cfg while disabled");
        enable_i = 1'b1;

        // Random configurations and traffic
        for (int t = 0; t < 60; t++) begin
            logic [31:0] mn, mx, st, nx;
            mn = 32'(($urandom % 64) * 4);
            mx = mn + 10240 + 32'(($urandom % 16) * 4);
            st = mx - 32'(($urandom % 8) * 4);
            if (st < mn) st = mn;
            if (st == mx) st = mx - 4;
            nx = st;
            case ($urandom % 6)
                0: mn = mn | 32'($urandom % 4);
                1: mx = 32'd65536 + 32'(($urandom % 3) * 4);
                2: mx = mn + 10236;
                default: ;
            endcase
            configure(mn, mx, nx, st, "R3 random cfg");
            for (int k = 0; k < 20; k++) begin
                if ($urandom % 3 == 0)
                    hdr_next_i = m_ok ? (m_min + 32'(($urandom % 8) * 4)) : 32'($urandom);
                if ($urandom % 25 == 0) enable_i = 1'b0;
                cycle(bit'($urandom % 4 != 0));
                enable_i = 1'b1;
            end
        end
        done = 1;
        finish_run();
    end
endmodule